// File: doc/BRIEF.md
# Command Intake Sequencer

This block takes a multi-byte command from a host, one byte at a time, through a small status and data register pair. Two status bits tell the host what to do. The ready bit says the block can take a byte now. The direction bit says which way data moves: 0 means host to block, 1 means block to host. The host writes a byte only when ready is 1 and direction is 0. Each write makes the block busy for a fixed processing time. It then asks for the next parameter byte, or it starts the command.

The first byte is the opcode. An internal table gives the number of parameter bytes that follow, from 0 to 8. An opcode missing from the table gives a one-cycle invalid-command pulse. The block then shows direction 1 until the host reads. Once the last parameter byte is processed, the block emits a one-cycle execute strobe. The captured opcode, the parameters and the parameter count stay on the outputs. The block waits with ready held at 0 until the execution engine reports that it is done. No data buffering is active while a command is being taken in. Each byte goes through the handshake on its own.

Top module: `cmd_intake`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `stat_ready`=1, `stat_dir`=0, `bad_cmd`=0 and `exec_go`=0.
- R2: A write accepted on an edge (with `host_wr`=1, `stat_ready`=1 and `stat_dir`=0) drives `stat_ready` to 0 from that edge. It stays 0 for `PROC_CYCLES` (default 2) cycles, and nothing else changes on the outputs until processing ends.
- R3: If further parameter bytes are needed once processing ends, `stat_ready` returns to 1 with `stat_dir`=0. This happens exactly once per parameter byte.
- R4: The number of parameter bytes per opcode is 0x03→2, 0x04→1, 0x05→8, 0x06→8, 0x07→1, 0x08→0, 0x0A→1, 0x0D→5, 0x0F→2, 0x12→1 and 0x13→3. Every other byte value is an invalid opcode.
- R5: When an invalid opcode finishes processing, `bad_cmd` pulses for one cycle and `stat_ready` is raised with `stat_dir`=1 on that same edge. While `stat_dir`=1, writes are ignored. A `host_rd` pulse returns the block to `stat_ready`=1, `stat_dir`=0.
- R6: When the last parameter byte finishes processing, `exec_go` pulses for one cycle. The outputs then hold `exec_opcode`, `exec_count` (the number of parameters) and `exec_params`. Parameter i sits in bits [8i+7:8i] and unused bytes are zero. `stat_ready` stays 0 until `exec_done` is pulsed, and after that the block returns to ready=1, dir=0.
- R7: A write while `stat_ready`=0 is ignored. It changes neither the captured bytes nor the byte sequence.
- R8: An opcode with zero parameters raises `exec_go` directly when its processing ends, and `stat_ready` is never raised in between.
- R9: `exec_done` has no effect except while waiting for execution, and `host_rd` has no effect except after an invalid opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host data-register write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host data-register read strobe (clears invalid state) |
| exec_done | input | 1 | Execution engine finished; return to command intake |
| stat_ready | output | 1 | Status: block can transfer a byte |
| stat_dir | output | 1 | Status: 0 host-to-block, 1 block-to-host |
| bad_cmd | output | 1 | One-cycle invalid-opcode pulse |
| exec_go | output | 1 | One-cycle execution start strobe |
| exec_opcode | output | 8 | Captured opcode |
| exec_params | output | 8*MAX_PARAMS | Captured parameter bytes, byte i at [8i+7:8i] |
| exec_count | output | IW | Number of captured parameter bytes |

## Verification
The tests use opcodes with 0, 1, several and the maximum 8 parameter bytes. These show whether the length lookup stops the request sequence at the right byte, and whether the zero-length path skips the ready phase. Invalid opcodes, some at the ends of the byte range, check the invalid flag and the reversed direction. A random mix of valid and arbitrary opcode bytes with random parameters checks the byte placement in `exec_params`. Random extra writes sent while busy or executing check that the block takes no byte while ready is low.

// File: rtl/cmd_intake.sv
module cmd_intake #(
  parameter int PROC_CYCLES = 2,
  parameter int MAX_PARAMS  = 8,
  parameter int IW          = $clog2(MAX_PARAMS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_wr,
  input  logic [7:0]              host_wdata,
  input  logic                    host_rd,
  input  logic                    exec_done,
  output logic                    stat_ready,
  output logic                    stat_dir,
  output logic                    bad_cmd,
  output logic                    exec_go,
  output logic [7:0]              exec_opcode,
  output logic [8*MAX_PARAMS-1:0] exec_params,
  output logic [IW-1:0]           exec_count
);
  localparam int CW = (PROC_CYCLES > 1) ? $clog2(PROC_CYCLES) : 1;

  typedef enum logic [1:0] {S_WAIT, S_PROC, S_EXEC, S_BAD} st_t;

  st_t                    st;
  logic                   have_op;
  logic [IW-1:0]          idx, need;
  logic [CW-1:0]          cnt;
  logic [7:0]             opcode;
  logic [8*MAX_PARAMS-1:0] params;
  logic [IW:0]            lk;

  function automatic logic [IW:0] cmd_len(input logic [7:0] op);
    case (op)
      8'h03:   return {1'b1, IW'(2)};
      8'h04:   return {1'b1, IW'(1)};
      8'h05:   return {1'b1, IW'(8)};
      8'h06:   return {1'b1, IW'(8)};
      8'h07:   return {1'b1, IW'(1)};
      8'h08:   return {1'b1, IW'(0)};
      8'h0A:   return {1'b1, IW'(1)};
      8'h0D:   return {1'b1, IW'(5)};
      8'h0F:   return {1'b1, IW'(2)};
      8'h12:   return {1'b1, IW'(1)};
      8'h13:   return {1'b1, IW'(3)};
      default: return {1'b0, IW'(0)};
    endcase
  endfunction

  assign lk          = cmd_len(opcode);
  assign stat_ready  = (st == S_WAIT) || (st == S_BAD);
  assign stat_dir    = (st == S_BAD);
  assign exec_opcode = opcode;
  assign exec_params = params;
  assign exec_count  = need;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_WAIT;
      have_op <= 1'b0;
      idx     <= '0;
      need    <= '0;
      cnt     <= '0;
      opcode  <= '0;
      params  <= '0;
      bad_cmd <= 1'b0;
      exec_go <= 1'b0;
    end else begin
      bad_cmd <= 1'b0;
      exec_go <= 1'b0;
      case (st)
        S_WAIT: if (host_wr) begin
          st  <= S_PROC;
          cnt <= CW'(PROC_CYCLES - 1);
          if (!have_op) begin
            opcode <= host_wdata;
            params <= '0;
          end else begin
            params[8*idx +: 8] <= host_wdata;
          end
        end
        S_PROC: if (cnt != '0) begin
          cnt <= cnt - CW'(1);
        end else if (!have_op) begin
          if (!lk[IW]) begin
            bad_cmd <= 1'b1;
            st      <= S_BAD;
          end else begin
            have_op <= 1'b1;
            need    <= lk[IW-1:0];
            idx     <= '0;
            if (lk[IW-1:0] == '0) begin
              exec_go <= 1'b1;
              st      <= S_EXEC;
            end else begin
              st <= S_WAIT;
            end
          end
        end else begin
          idx <= idx + IW'(1);
          if (idx + IW'(1) == need) begin
            exec_go <= 1'b1;
            st      <= S_EXEC;
          end else begin
            st <= S_WAIT;
          end
        end
        S_EXEC: if (exec_done) begin
          st      <= S_WAIT;
          have_op <= 1'b0;
          idx     <= '0;
        end
        S_BAD: if (host_rd) begin
          st      <= S_WAIT;
          have_op <= 1'b0;
        end
        default: st <= S_WAIT;
      endcase
    end
  end
endmodule

module cmd_intake_chk (
  input logic clk,
  input logic rst,
  input logic host_wr,
  input logic stat_ready,
  input logic stat_dir,
  input logic bad_cmd,
  input logic exec_go
);
  AST_WR_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (host_wr && stat_ready && !stat_dir) |=> !stat_ready); // R2
  AST_READY_LOW_TWO: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_ready) |=> !stat_ready); // R2
  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    exec_go |=> !exec_go); // R6
  AST_GO_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    exec_go |-> (!stat_ready && !stat_dir)); // R6
  AST_BAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bad_cmd |=> !bad_cmd); // R5
  AST_BAD_TURNS_DIR: assert property (@(posedge clk) disable iff (rst)
    bad_cmd |-> (stat_ready && stat_dir)); // R5
  AST_GO_BAD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(exec_go && bad_cmd)); // R4
endmodule

bind cmd_intake cmd_intake_chk chk_i (.*);

// File: tb/cmd_intake_tb.sv
module cmd_intake_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic        host_rd = 1'b0;
  logic        exec_done = 1'b0;
  logic        stat_ready, stat_dir, bad_cmd, exec_go;
  logic [7:0]  exec_opcode;
  logic [63:0] exec_params;
  logic [3:0]  exec_count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  cmd_intake dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .exec_done(exec_done), .stat_ready(stat_ready),
    .stat_dir(stat_dir), .bad_cmd(bad_cmd), .exec_go(exec_go),
    .exec_opcode(exec_opcode), .exec_params(exec_params), .exec_count(exec_count)
  );

  function automatic int exp_len(input logic [7:0] op);
    case (op)
      8'h03, 8'h0F:                return 2;
      8'h04, 8'h07, 8'h0A, 8'h12:  return 1;
      8'h05, 8'h06:                return 8;
      8'h08:                       return 0;
      8'h0D:                       return 5;
      8'h13:                       return 3;
      default:                     return -1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit junk);
    host_wr = 1'b1; host_wdata = b;
    @(negedge clk); host_wr = 1'b0;
    chk(stat_ready == 1'b0, "R2", "ready after write", stat_ready, 0);
    if (junk) begin host_wr = 1'b1; host_wdata = 8'($urandom); end
    @(negedge clk); host_wr = 1'b0;
    chk(stat_ready == 1'b0 && !exec_go && !bad_cmd, "R2", "still busy",
        {exec_go, bad_cmd, stat_ready}, 0);
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [7:0] p [8], input bit junk);
    int n;
    logic [63:0] ep;
    n = exp_len(op);
    ep = '0;
    send(op, junk);
    if (n < 0) begin
      chk(bad_cmd && stat_ready && stat_dir, "R5", "invalid flag", {bad_cmd, stat_ready, stat_dir}, 3'b111);
      @(negedge clk);
      chk(!bad_cmd, "R5", "invalid pulse width", bad_cmd, 0);
      host_wr = 1'b1; host_wdata = 8'h04;
      @(negedge clk); host_wr = 1'b0;
      @(negedge clk);
      chk(stat_ready && stat_dir && !exec_go, "R5", "write ignored while dir=1", {stat_ready, stat_dir}, 2'b11);
      host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0;
      chk(stat_ready && !stat_dir, "R5", "read clears", {stat_ready, stat_dir}, 2'b10);
      return;
    end
    if (n == 0) begin
      chk(exec_go && !stat_ready, "R8", "zero-param go", {exec_go, stat_ready}, 2'b10);
    end else begin
      chk(stat_ready && !stat_dir && !exec_go, "R3", "request first param", {stat_ready, stat_dir, exec_go}, 3'b100);
      for (int i = 0; i < n; i++) begin
        ep[8*i +: 8] = p[i];
        send(p[i], junk);
        if (i < n - 1)
          chk(stat_ready && !exec_go, "R3", "request next param", {stat_ready, exec_go}, 2'b10);
        else
          chk(exec_go && !stat_ready, "R6", "go after last", {exec_go, stat_ready}, 2'b10);
      end
    end
    chk(exec_opcode == op, "R4", "opcode", exec_opcode, op);
    chk(exec_count == 4'(n), "R4", "param count", exec_count, n);
    chk(exec_params == ep, "R6", "params", exec_params, ep);
    @(negedge clk);
    chk(!exec_go && !stat_ready, "R6", "waiting for done", {exec_go, stat_ready}, 0);
    host_wr = 1'b1; host_wdata = 8'($urandom);
    @(negedge clk); host_wr = 1'b0;
    @(negedge clk);
    chk(exec_params == ep && exec_opcode == op && !stat_ready, "R7", "write during exec ignored", exec_params, ep);
    exec_done = 1'b1;
    @(negedge clk); exec_done = 1'b0;
    chk(stat_ready && !stat_dir, "R6", "done returns to intake", {stat_ready, stat_dir}, 2'b10);
  endtask

  initial begin
    #(100000 * 4ns);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] p [8];
    logic [7:0] valid_ops [11] = '{8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08,
                                   8'h0A, 8'h0D, 8'h0F, 8'h12, 8'h13};
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(stat_ready && !stat_dir && !bad_cmd && !exec_go, "R1", "reset state",
        {stat_ready, stat_dir, bad_cmd, exec_go}, 4'b1000);

    exec_done = 1'b1; host_rd = 1'b1;
    @(negedge clk); exec_done = 1'b0; host_rd = 1'b0;
    @(negedge clk);
    chk(stat_ready && !stat_dir && !exec_go, "R9", "stray done/read ignored", {stat_ready, stat_dir}, 2'b10);

    for (int i = 0; i < 8; i++) p[i] = 8'(8'hA0 + i);
    run_cmd(8'h08, p, 1'b0);
    run_cmd(8'h06, p, 1'b0);
    run_cmd(8'h04, p, 1'b1);
    run_cmd(8'hFF, p, 1'b0);
    run_cmd(8'h00, p, 1'b1);
    run_cmd(8'h0D, p, 1'b1);

    for (int k = 0; k < 40; k++) begin
      logic [7:0] op;
      for (int i = 0; i < 8; i++) p[i] = 8'($urandom);
      if ($urandom % 2) op = valid_ops[$urandom % 11];
      else op = 8'($urandom);
      run_cmd(op, p, 1'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule